// File: doc/BRIEF.md
# Band-Energy Tone Shape Classifier

This block receives one spectrum frame at a time as a stream of magnitude values, one per frequency bin, in rising bin order. Each bin carries its index. A one-cycle end-of-frame strobe closes the frame. The block groups the bins into 5 kHz wide bands and accumulates the energy of each band. It then keeps the two strongest bands and decides for each one whether the tone is a sine or a triangle. A triangle spends part of its energy on its third harmonic, so its fundamental band holds less energy than a sine of the same swing.

The two results go out as a six-byte message on a valid/ready byte port: a header byte, then shape and frequency for the lower tone, then shape and frequency for the higher tone, then a trailer byte. A downstream serial sender or controller consumes the message and rebuilds the two tones. Magnitudes are unsigned fixed point with 8 fractional bits. The threshold is compared in the squared domain, so the block takes no square root.

Top module: `tone_shape_classifier`

## Requirements
- R1: Only bins with index 35 to 999 inclusive contribute. Bins outside that range have no effect on the message.
- R2: A bin belongs to band floor((index*100 + 512) / 1024), which is index*1e6/2048/5000 rounded to the nearest integer. Consecutive bins of the same band are merged, and a band's energy is the sum of the squares of its bin magnitudes.
- R3: A frequency field carries the band number, in units of 5 kHz.
- R4: Bands are ranked in the order they close. A band whose energy is strictly greater than the current top becomes the top, and the old top becomes second. Otherwise, a band whose energy is strictly greater than the current second replaces the second. Ties leave the earlier band in place.
- R5: The shape code is 0 (sine) when the band energy is greater than 2129264 (5.7 squared in units of 2^-16). Otherwise the code is 1 (triangle).
- R6: Of the two kept bands, the one with the lower band number is reported first, as tone A.
- R7: If the second band has zero energy (fewer than two bands with energy), both frequency fields are 0. The top band's shape is sent first, and the empty band's shape (1) second.
- R8: The message is 0xFF, shape A, frequency A, shape B, frequency B, 0xFE, sent one byte per out_valid/out_ready transfer. A stalled byte holds its value.
- R9: The end-of-frame strobe closes a band that is still open. All band and peak state clears, so no energy carries into the next frame.
- R10: From an accepted end-of-frame strobe until the last message byte is accepted, the block ignores bin inputs and further end-of-frame strobes.
- R11: After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bin_valid | input | 1 | A bin value is present this cycle |
| bin_idx | input | 11 | Bin index, rising within a frame |
| bin_mag | input | 16 | Bin magnitude, unsigned, 8 fractional bits |
| frame_done | input | 1 | One-cycle strobe that ends the frame |
| out_valid | output | 1 | A message byte is offered |
| out_ready | input | 1 | Downstream accepts the offered byte |
| out_data | output | 8 | Message byte |

## Verification
The assertions check on every cycle that:
- the ranked pair stays ordered by energy;
- a produced result never places the higher band first;
- a stalled byte holds its value;
- each message opens with the header;
- nothing is emitted while the block is blocked.

Only the bench scenarios can show the arithmetic. They cover the band mapping and the merging of bins, the threshold edge (one bin at 1459 against one at 1460), tie handling, the range filter, the empty-band fallback, the clearing of state between frames, and the rejection of input during a pending message. Each is compared with a model that rebuilds the band sums from the raw bins.

// File: rtl/tsc_pkg.sv
// Shared constants and types for the tone shape classifier.
// Assumes 8-bit message bytes and a 4-field result record.
package tsc_pkg;
    localparam logic [7:0] MSG_HEAD  = 8'hFF;
    localparam logic [7:0] MSG_TAIL  = 8'hFE;
    localparam logic [7:0] SHAPE_SIN = 8'd0;
    localparam logic [7:0] SHAPE_TRI = 8'd1;
    localparam int         MSG_LEN   = 6;

    typedef struct packed {
        logic [7:0] shape_a;
        logic [7:0] freq_a;
        logic [7:0] shape_b;
        logic [7:0] freq_b;
    } tsc_result_t;
endpackage

// File: rtl/tsc_band_accum.sv
// Band energy accumulator.
// Maps each in-range bin to its band and sums the squared magnitudes of the
// bins in a band. When a band closes, it emits the band number and its sum.
// The end-of-frame strobe closes any open band and pulses end_v.
// Assumes bins arrive in rising order and that hold blocks all input.
module tsc_band_accum #(
    parameter int BIN_W      = 11,
    parameter int MAG_W      = 16,
    parameter int BAND_W     = 8,
    parameter int ACC_W      = 2*MAG_W + 4,
    parameter int BIN_LO     = 35,
    parameter int BIN_HI     = 999,
    parameter int BAND_MUL   = 100,
    parameter int BAND_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              bin_valid,
    input  logic [BIN_W-1:0]  bin_idx,
    input  logic [MAG_W-1:0]  bin_mag,
    input  logic              frame_done,
    output logic              close_v,
    output logic [BAND_W-1:0] close_band,
    output logic [ACC_W-1:0]  close_sum,
    output logic              end_v
);
    localparam int HALF = 1 << (BAND_SHIFT - 1);
    localparam int SQ_W = 2 * MAG_W;

    logic              in_rng;
    logic              take;
    logic              fin;
    logic [BAND_W-1:0] bin_band;
    logic [SQ_W-1:0]   sq;
    logic              open_q;
    logic [BAND_W-1:0] cur_band;
    logic [ACC_W-1:0]  acc;

    // Decode the range, the band number and the squared magnitude of this bin.
    always_comb begin
        in_rng   = (bin_idx >= BIN_W'(BIN_LO)) && (bin_idx <= BIN_W'(BIN_HI));
        bin_band = BAND_W'(((32'(bin_idx) * BAND_MUL) + HALF) >> BAND_SHIFT);
        sq       = SQ_W'(bin_mag) * SQ_W'(bin_mag);
        fin      = frame_done && !hold;
        take     = bin_valid && in_rng && !hold && !frame_done;
    end

    // Merge bins into the open band, close it on a band change or at end of frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q     <= 1'b0;
            cur_band   <= '0;
            acc        <= '0;
            close_v    <= 1'b0;
            close_band <= '0;
            close_sum  <= '0;
            end_v      <= 1'b0;
        end else begin
            close_v <= 1'b0;
            end_v   <= 1'b0;
            if (fin) begin
                if (open_q) begin
                    close_v    <= 1'b1;
                    close_band <= cur_band;
                    close_sum  <= acc;
                end
                end_v  <= 1'b1;
                open_q <= 1'b0;
                acc    <= '0;
            end else if (take) begin
                if (open_q && (bin_band == cur_band)) begin
                    acc <= acc + ACC_W'(sq);
                end else begin
                    if (open_q) begin
                        close_v    <= 1'b1;
                        close_band <= cur_band;
                        close_sum  <= acc;
                    end
                    cur_band <= bin_band;
                    acc      <= ACC_W'(sq);
                    open_q   <= 1'b1;
                end
            end
        end
    end

    // R10: a blocked cycle never produces a band close or an end pulse.
    p_hold_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!close_v && !end_v));
endmodule

// File: rtl/tsc_peak_pick.sv
// Two-strongest peak tracker and shape decision.
// Ranks closed bands by energy with strict comparisons. At end of frame it
// forms the ordered (shape, frequency) pair and then clears its state.
// Assumes a close that arrives with end_v belongs to the same frame.
module tsc_peak_pick
    import tsc_pkg::*;
#(
    parameter int BAND_W = 8,
    parameter int ACC_W  = 36,
    parameter int THR_SQ = 2129264
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              close_v,
    input  logic [BAND_W-1:0] close_band,
    input  logic [ACC_W-1:0]  close_sum,
    input  logic              end_v,
    output logic              res_v,
    output tsc_result_t       res
);
    logic [ACC_W-1:0]  m0_s, m1_s, n0_s, n1_s;
    logic [BAND_W-1:0] m0_b, m1_b, n0_b, n1_b;
    tsc_result_t       res_n;

    function automatic logic [7:0] shape_of(input logic [ACC_W-1:0] s);
        return (s > ACC_W'(THR_SQ)) ? SHAPE_SIN : SHAPE_TRI;
    endfunction

    // Apply this cycle's close to the ranked pair.
    always_comb begin
        n0_s = m0_s; n0_b = m0_b;
        n1_s = m1_s; n1_b = m1_b;
        if (close_v) begin
            if (close_sum > m0_s) begin
                n1_s = m0_s;      n1_b = m0_b;
                n0_s = close_sum; n0_b = close_band;
            end else if (close_sum > m1_s) begin
                n1_s = close_sum; n1_b = close_band;
            end
        end
    end

    // Build the ordered result from the updated pair.
    always_comb begin
        if (n1_s == '0) begin
            res_n.shape_a = shape_of(n0_s); res_n.freq_a = 8'd0;
            res_n.shape_b = shape_of(n1_s); res_n.freq_b = 8'd0;
        end else if (n0_b < n1_b) begin
            res_n.shape_a = shape_of(n0_s); res_n.freq_a = 8'(n0_b);
            res_n.shape_b = shape_of(n1_s); res_n.freq_b = 8'(n1_b);
        end else begin
            res_n.shape_a = shape_of(n1_s); res_n.freq_a = 8'(n1_b);
            res_n.shape_b = shape_of(n0_s); res_n.freq_b = 8'(n0_b);
        end
    end

    // Hold the ranked pair, publish on end of frame and clear for the next frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m0_s <= '0; m0_b <= '0; m1_s <= '0; m1_b <= '0;
            res_v <= 1'b0;
            res   <= '0;
        end else begin
            res_v <= 1'b0;
            if (end_v) begin
                res   <= res_n;
                res_v <= 1'b1;
                m0_s <= '0; m0_b <= '0; m1_s <= '0; m1_b <= '0;
            end else begin
                m0_s <= n0_s; m0_b <= n0_b; m1_s <= n1_s; m1_b <= n1_b;
            end
        end
    end

    // R4: the top entry never holds less energy than the second.
    p_rank_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
        m0_s >= m1_s);
    // R6: a published result never places the higher band first.
    p_low_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_v |-> (res.freq_a <= res.freq_b));
endmodule

// File: rtl/tsc_msg_out.sv
// Message serializer.
// Loads a result and sends header, four fields and trailer, one byte per
// valid/ready transfer. Assumes load arrives only while idle.
module tsc_msg_out
    import tsc_pkg::*;
#(
    parameter int LEN = MSG_LEN
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  tsc_result_t res,
    output logic        active,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [7:0]  out_data
);
    localparam int IDX_W = $clog2(LEN);

    logic [LEN*8-1:0] frame_q;
    logic [IDX_W-1:0] idx;

    // Present the byte at the current position.
    always_comb begin
        out_valid = active;
        out_data  = frame_q[(LEN-1-int'(idx))*8 +: 8];
    end

    // Capture a message on load and step through it on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            idx     <= '0;
            frame_q <= '0;
        end else if (load && !active) begin
            frame_q <= {MSG_HEAD, res.shape_a, res.freq_a, res.shape_b, res.freq_b, MSG_TAIL};
            idx     <= '0;
            active  <= 1'b1;
        end else if (active && out_ready) begin
            if (idx == IDX_W'(LEN-1)) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    // R8: a stalled byte stays offered and unchanged.
    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    // R8: every message opens with the header byte.
    p_header_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_data == MSG_HEAD));
    // R10: a new result never lands on a message still in flight.
    p_load_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !active);
endmodule

// File: rtl/tone_shape_classifier.sv
// Top of the tone shape classifier.
// Chains the band accumulator, the peak tracker and the message serializer.
// Blocks input from an accepted end of frame until the message drains.
module tone_shape_classifier
    import tsc_pkg::*;
#(
    parameter int BIN_W  = 11,
    parameter int MAG_W  = 16,
    parameter int BAND_W = 8,
    parameter int BIN_LO = 35,
    parameter int BIN_HI = 999,
    parameter int THR_SQ = 2129264
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bin_valid,
    input  logic [BIN_W-1:0] bin_idx,
    input  logic [MAG_W-1:0] bin_mag,
    input  logic             frame_done,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [7:0]       out_data
);
    localparam int ACC_W = 2*MAG_W + 4;

    logic              close_v, end_v, res_v, tx_active, busy;
    logic [BAND_W-1:0] close_band;
    logic [ACC_W-1:0]  close_sum;
    tsc_result_t       res;

    // Blocked while a frame's result is in the pipe or on the port.
    always_comb busy = end_v || res_v || tx_active;

    tsc_band_accum #(
        .BIN_W(BIN_W), .MAG_W(MAG_W), .BAND_W(BAND_W), .ACC_W(ACC_W),
        .BIN_LO(BIN_LO), .BIN_HI(BIN_HI), .BAND_MUL(100), .BAND_SHIFT(10)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .hold(busy),
        .bin_valid(bin_valid), .bin_idx(bin_idx), .bin_mag(bin_mag),
        .frame_done(frame_done),
        .close_v(close_v), .close_band(close_band), .close_sum(close_sum),
        .end_v(end_v)
    );

    tsc_peak_pick #(
        .BAND_W(BAND_W), .ACC_W(ACC_W), .THR_SQ(THR_SQ)
    ) u_peak (
        .clk(clk), .rst_n(rst_n),
        .close_v(close_v), .close_band(close_band), .close_sum(close_sum),
        .end_v(end_v), .res_v(res_v), .res(res)
    );

    tsc_msg_out #(.LEN(MSG_LEN)) u_out (
        .clk(clk), .rst_n(rst_n), .load(res_v), .res(res),
        .active(tx_active), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );
endmodule

// File: tb/tone_shape_classifier_test.sv
`timescale 1ns/1ps
module tone_shape_classifier_test;
    localparam int THR = 2129264;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bin_valid = 1'b0;
    logic [10:0] bin_idx = '0;
    logic [15:0] bin_mag = '0;
    logic        frame_done = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;

    int compared = 0;
    int mismatched = 0;
    bit stall = 1'b0;
    bit done_flag = 1'b0;
    logic [15:0] mags [0:1023];
    int    exp_q[$];
    string tag_q[$];
    int    rx_q[$];

    always #10 clk = ~clk;

    tone_shape_classifier uut (
        .clk(clk), .rst_n(rst_n), .bin_valid(bin_valid), .bin_idx(bin_idx),
        .bin_mag(bin_mag), .frame_done(frame_done), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    function automatic int band_of(int b);
        return (b * 100 + 512) / 1024;
    endfunction

    function automatic int first_bin(int k);
        for (int b = 35; b <= 999; b++) if (band_of(b) == k) return b;
        return 0;
    endfunction

    task automatic check(string req, int got, int expv);
        compared++;
        if (got != expv) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic clear_mags();
        for (int b = 0; b < 1024; b++) mags[b] = '0;
    endtask

    task automatic set_band(int k, int nbins, int m);
        int b = first_bin(k);
        for (int i = 0; i < nbins; i++)
            if (band_of(b + i) == k) mags[b + i] = 16'(m);
    endtask

    // Model: R1 range, R2 band sums, R4 ranking, R5 shape, R6/R7 ordering.
    task automatic expect_frame(string tag);
        longint sums [0:127];
        longint t0s = 0, t1s = 0;
        int t0b = 0, t1b = 0;
        int sa, sb, fa, fb;
        for (int k = 0; k < 128; k++) sums[k] = 0;
        for (int b = 35; b <= 999; b++)
            sums[band_of(b)] += longint'(mags[b]) * longint'(mags[b]);
        for (int k = 0; k < 128; k++) begin
            if (sums[k] > t0s) begin
                t1s = t0s; t1b = t0b; t0s = sums[k]; t0b = k;
            end else if (sums[k] > t1s) begin
                t1s = sums[k]; t1b = k;
            end
        end
        if (t1s == 0) begin
            sa = (t0s > THR) ? 0 : 1; fa = 0;
            sb = (t1s > THR) ? 0 : 1; fb = 0;
        end else if (t0b < t1b) begin
            sa = (t0s > THR) ? 0 : 1; fa = t0b;
            sb = (t1s > THR) ? 0 : 1; fb = t1b;
        end else begin
            sa = (t1s > THR) ? 0 : 1; fa = t1b;
            sb = (t0s > THR) ? 0 : 1; fb = t0b;
        end
        exp_q.push_back(8'hFF); tag_q.push_back({tag, " header R8"});
        exp_q.push_back(sa);    tag_q.push_back({tag, " shape A R5"});
        exp_q.push_back(fa);    tag_q.push_back({tag, " freq A R3 R6"});
        exp_q.push_back(sb);    tag_q.push_back({tag, " shape B R5"});
        exp_q.push_back(fb);    tag_q.push_back({tag, " freq B R3 R6"});
        exp_q.push_back(8'hFE); tag_q.push_back({tag, " trailer R8"});
    endtask

    task automatic wait_drain();
        for (int i = 0; i < 4000 && rx_q.size() < exp_q.size(); i++) @(posedge clk);
    endtask

    task automatic stream_bins();
        for (int b = 0; b < 1024; b++) begin
            @(negedge clk);
            if ($urandom % 5 == 0) begin
                bin_valid = 1'b0; bin_idx = 11'($urandom); bin_mag = 16'($urandom);
                @(negedge clk);
            end
            bin_valid = 1'b1; bin_idx = 11'(b); bin_mag = mags[b];
        end
        @(negedge clk);
        bin_valid = 1'b0;
    endtask

    task automatic send_frame(string tag, bit drain);
        stream_bins();
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        expect_frame(tag);
        if (drain) wait_drain();
    endtask

    // Output sink: random ready, sampled away from the clock edge.
    initial begin
        forever begin
            @(negedge clk);
            out_ready = stall ? 1'b0 : ($urandom % 4 != 0);
            #1;
            if (out_valid && out_ready) rx_q.push_back(int'(out_data));
        end
    end

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        compared++; mismatched++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (4) @(negedge clk);
        check("R11 out_valid after reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 out_valid idle", int'(out_valid), 0);

        // R5 threshold edge: one bin at 1460 (sine), one at 1459 (triangle).
        clear_mags(); set_band(8, 1, 1460); set_band(15, 1, 1459);
        send_frame("R5 threshold", 1'b1);
        // R2 merging: many weak bins sum past threshold, few stay below.
        clear_mags(); set_band(10, 12, 500); set_band(20, 3, 700);
        send_frame("R2 merge", 1'b1);
        // R6 ordering: stronger tone at higher band.
        clear_mags(); set_band(30, 4, 3000); set_band(12, 2, 900);
        send_frame("R6 order", 1'b1);
        // R4 ties: three equal bands, earlier two kept.
        clear_mags(); set_band(9, 1, 1200); set_band(25, 1, 1200); set_band(40, 1, 1200);
        send_frame("R4 tie", 1'b1);
        // R4 demotion: weak first, then stronger, then middle.
        clear_mags(); set_band(5, 1, 800); set_band(18, 1, 2500); set_band(50, 1, 1000);
        send_frame("R4 demote", 1'b1);
        // R7: a single band, then an empty frame.
        clear_mags(); set_band(14, 3, 2000);
        send_frame("R7 single", 1'b1);
        clear_mags();
        send_frame("R7 empty", 1'b1);
        // R1: huge out-of-range bins.
        clear_mags();
        for (int b = 0; b < 35; b++) mags[b] = 16'hFFFF;
        for (int b = 1000; b < 1024; b++) mags[b] = 16'hFFFF;
        set_band(6, 2, 1500); set_band(16, 2, 700);
        send_frame("R1 range", 1'b1);
        // R9: band open at the final bin is closed by the strobe.
        clear_mags(); mags[999] = 16'd3000; mags[998] = 16'd3000; set_band(40, 1, 900);
        send_frame("R9 last band", 1'b1);
        // R9: the next frame carries no energy from before.
        clear_mags(); set_band(22, 1, 600); set_band(7, 1, 400);
        send_frame("R9 clear", 1'b1);

        // R10: input during a pending message is ignored.
        clear_mags(); set_band(11, 2, 1800); set_band(33, 1, 1000);
        stream_bins();
        stall = 1'b1;
        frame_done = 1'b1;
        @(negedge clk);
        frame_done = 1'b0;
        expect_frame("R10 held");
        for (int i = 0; i < 200; i++) begin
            bin_valid = 1'b1; bin_idx = 11'(100 + i); bin_mag = 16'hFFFF;
            frame_done = (i == 150);
            @(negedge clk);
        end
        bin_valid = 1'b0; frame_done = 1'b0;
        stall = 1'b0;
        wait_drain();
        clear_mags(); set_band(19, 1, 1300); set_band(44, 1, 1100);
        send_frame("R10 after", 1'b1);

        // Random frames: noise floor plus two tones.
        for (int f = 0; f < 6; f++) begin
            int ka = 4 + int'($urandom % 17);
            int kb = 4 + int'($urandom % 17);
            if (kb == ka) kb = ka + 20;
            for (int b = 0; b < 1024; b++) mags[b] = 16'($urandom % 128);
            set_band(ka, 1 + int'($urandom % 4), 800 + int'($urandom % 2200));
            set_band(kb, 1 + int'($urandom % 4), 800 + int'($urandom % 2200));
            send_frame("R2 random", 1'b1);
        end

        repeat (50) @(posedge clk);
        @(negedge clk);
        check("R10 message byte count", rx_q.size(), exp_q.size());
        for (int i = 0; i < exp_q.size(); i++) begin
            if (i < rx_q.size()) check(tag_q[i], rx_q[i], exp_q[i]);
            else check(tag_q[i], -1, exp_q[i]);
        end
        finish_run();
    end
endmodule